// File: doc/BRIEF.md
# Watchdog timer with keyed enable

This block is a watchdog peripheral on a simple APB-style register bus. Once running, a counter advances every clock. When the counter reaches the interrupt period, the block sets a pending flag, and the interrupt line follows that flag under a mask. When the counter reaches the longer reset period and reset arming is on, the block drives a reset request for a fixed number of cycles. It then records a cause flag, and the counter starts again from zero. Software keeps the counter from expiring by writing a two-word feed pattern to the service register.

The run bit cannot be set by a single stray write. Two key words must be written to the control register first, and the write that sets the run bit must follow them directly. The run bit, the reset-arm bit and the cause flag sit in the power-on reset domain. The system reset that the watchdog itself requests therefore leaves them intact, and the watchdog keeps guarding the system after the reset it caused.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset the control register reads 0x00000000, and `irq_o` and `rst_req_o` are low.
- R2: The control register is at offset 0x0, with run at bit 8, interrupt pending at bit 9, interrupt mask at bit 10, reset arm at bit 11 and cause at bit 31. All other bits read 0. Reads at offset 0x4 return 0.
- R3: Run becomes 1 only through a control write with bit 8 set that directly follows control writes of exactly 0x000000A5 and then 0x0000005A. Any other control write in between restarts the sequence.
- R4: A control write with bit 8 clear stops the counter without any key words. While run is 0 the counter is held at zero, so a later enable counts from zero.
- R5: A control write of exactly 0x000000A5 or 0x0000005A changes no field of the control register.
- R6: With the counter starting from zero, pending becomes 1 exactly 2^IRQ_EXP cycles later. Writing 1 to bit 9 clears it, and writing 0 to bit 9 leaves it set.
- R7: `irq_o` is high exactly when pending and the interrupt mask bit are both 1.
- R8: Writing 0x000000A5 and then 0x0000005A to offset 0x4 zeroes the counter on the second write. Any other value, or a sequence broken by another value, leaves the counter running.
- R9: With reset arm at 1, `rst_req_o` rises 2^RST_EXP cycles after the counter starts from zero and stays high for PULSE_LEN cycles. The next request follows 2^RST_EXP cycles after the pulse ends.
- R10: The cause flag becomes 1 on the cycle `rst_req_o` rises. Writing 0 to bit 31 clears it, and writing 1 leaves it unchanged.
- R11: System reset clears the interrupt mask, pending, the counter and both key sequences, and leaves run, reset arm and cause unchanged. Power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high, read when low |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions take for granted that no bus write arrives while system reset is held, and that power-on reset is asserted together with system reset. Under those two conditions, the run bit can only move through a write. The stimulus issues every access only after both resets have been released. It changes the bus signals one time unit after a falling edge, so each access phase lasts exactly one cycle. Reads are placed away from the cycles where the counter reaches a period, so that no read value depends on a flag that sets during the access itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_W = 32;

    // byte offsets of the two registers
    localparam int CTRL_OFS = 0;
    localparam int FEED_OFS = 4;

    // key words for the unlock and feed sequences
    localparam logic [REG_W-1:0] KEY_ONE = 32'h0000_00A5;
    localparam logic [REG_W-1:0] KEY_TWO = 32'h0000_005A;

    // control register field positions
    localparam int RUN_BIT   = 8;
    localparam int PEND_BIT  = 9;
    localparam int MASK_BIT  = 10;
    localparam int ARM_BIT   = 11;
    localparam int CAUSE_BIT = 31;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_HALF,
        SEQ_OPEN
    } seq_st_e;

    // fields that only power-on reset clears
    typedef struct packed {
        logic run;
        logic arm;
        logic cause;
    } por_regs_t;

    // fields that system reset clears
    typedef struct packed {
        logic mask;
        logic pend;
    } sys_regs_t;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
#(
    parameter bit HOLD = 1'b1   // 1: hit_o held until next write; 0: one-cycle hit on second key
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] data_i,
    output logic             hit_o
);

    typedef struct packed {
        seq_st_e st;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       second_ok;

    always_comb begin
        s_d       = s_q;
        second_ok = 1'b0;
        if (wr_i) begin
            if (data_i == KEY_ONE) begin
                s_d.st = SEQ_HALF;
            end else if (s_q.st == SEQ_HALF && data_i == KEY_TWO) begin
                second_ok = 1'b1;
                s_d.st    = HOLD ? SEQ_OPEN : SEQ_IDLE;
            end else begin
                s_d.st = SEQ_IDLE;
            end
        end
    end

    generate
        if (HOLD) begin : g_hold
            assign hit_o = (s_q.st == SEQ_OPEN);
        end else begin : g_pulse
            assign hit_o = second_ok;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    // R3
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_OPEN && $past(s_q.st) != SEQ_OPEN)
            |-> $past(wr_i && data_i == KEY_TWO));

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int IRQ_EXP   = 10,
    parameter int RST_EXP   = 14,
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic por_n,
    input  logic run_i,
    input  logic arm_i,
    input  logic feed_i,
    output logic irq_hit_o,
    output logic rst_start_o,
    output logic rst_req_o
);

    localparam int CW = RST_EXP;
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] IRQ_LAST = CW'((64'd1 << IRQ_EXP) - 64'd1);
    localparam logic [CW-1:0] RST_LAST = {CW{1'b1}};
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    typedef struct packed {
        logic [PW-1:0] left;
    } pls_state_t;

    cnt_state_t c_d, c_q;
    pls_state_t p_d, p_q;
    logic       busy;

    always_comb begin
        c_d         = c_q;
        p_d         = p_q;
        busy        = (p_q.left != '0);
        irq_hit_o   = run_i && !busy && (c_q.cnt == IRQ_LAST);
        rst_start_o = run_i && arm_i && !busy && (c_q.cnt == RST_LAST);

        if (!run_i || busy || feed_i || rst_start_o) begin
            c_d.cnt = '0;
        end else begin
            c_d.cnt = c_q.cnt + 1'b1;
        end

        if (rst_start_o) begin
            p_d.left = PULSE_LOAD;
        end else if (busy) begin
            p_d.left = p_q.left - 1'b1;
        end
    end

    assign rst_req_o = (p_q.left != '0);

    // counter lives in the system reset domain
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            c_q <= '{cnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    // pulse survives the reset it requests
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            p_q <= '{left: '0};
        end else begin
            p_q <= p_d;
        end
    end

    // R9
    pulse_follows_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_start_o |=> rst_req_o);

    // R8
    feed_zeroes_cnt_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        feed_i |=> (c_q.cnt == '0));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int IRQ_EXP   = 10,
    parameter int RST_EXP   = 14,
    parameter int PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int NSEQ = 2;   // 0: control unlock, 1: feed
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] FEED_A = ADDR_W'(FEED_OFS);

    logic sys_arst_n;
    logic bus_wr, ctrl_wr, feed_wr, is_key, fld_wr, rd_ctrl;
    logic [NSEQ-1:0] seq_wr, seq_hit;
    logic irq_hit, rst_start;

    por_regs_t por_d, por_q;
    sys_regs_t sys_d, sys_q;

    assign sys_arst_n = sys_rst_n & por_n;
    assign bus_wr     = psel & penable & pwrite;
    assign ctrl_wr    = bus_wr && (paddr == CTRL_A);
    assign feed_wr    = bus_wr && (paddr == FEED_A);
    assign is_key     = (pwdata == KEY_ONE) || (pwdata == KEY_TWO);
    assign fld_wr     = ctrl_wr && !is_key;
    assign rd_ctrl    = psel && !pwrite && (paddr == CTRL_A);
    assign seq_wr     = {feed_wr, ctrl_wr};

    generate
        for (genvar g = 0; g < NSEQ; g++) begin : g_seq
            wdog_keyseq #(
                .HOLD (g == 0)
            ) u_seq (
                .clk    (clk),
                .rst_n  (sys_arst_n),
                .wr_i   (seq_wr[g]),
                .data_i (pwdata),
                .hit_o  (seq_hit[g])
            );
        end
    endgenerate

    wdog_timebase #(
        .IRQ_EXP   (IRQ_EXP),
        .RST_EXP   (RST_EXP),
        .PULSE_LEN (PULSE_LEN)
    ) u_tb (
        .clk         (clk),
        .sys_rst_n   (sys_arst_n),
        .por_n       (por_n),
        .run_i       (por_q.run),
        .arm_i       (por_q.arm),
        .feed_i      (seq_hit[1]),
        .irq_hit_o   (irq_hit),
        .rst_start_o (rst_start),
        .rst_req_o   (rst_req_o)
    );

    always_comb begin
        por_d = por_q;
        sys_d = sys_q;
        if (fld_wr) begin
            por_d.run  = pwdata[RUN_BIT] & (por_q.run | seq_hit[0]);
            por_d.arm  = pwdata[ARM_BIT];
            sys_d.mask = pwdata[MASK_BIT];
            if (!pwdata[CAUSE_BIT]) por_d.cause = 1'b0;
            if (pwdata[PEND_BIT])   sys_d.pend  = 1'b0;
        end
        if (rst_start) por_d.cause = 1'b1;
        if (irq_hit)   sys_d.pend  = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            por_q <= '0;
        end else begin
            por_q <= por_d;
        end
    end

    always_ff @(posedge clk or negedge sys_arst_n) begin
        if (!sys_arst_n) begin
            sys_q <= '0;
        end else begin
            sys_q <= sys_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_ctrl) begin
            prdata[RUN_BIT]   = por_q.run;
            prdata[PEND_BIT]  = sys_q.pend;
            prdata[MASK_BIT]  = sys_q.mask;
            prdata[ARM_BIT]   = por_q.arm;
            prdata[CAUSE_BIT] = por_q.cause;
        end
    end

    assign irq_o = sys_q.pend & sys_q.mask;

    // R3
    run_needs_key_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_q.run) |-> $past(seq_hit[0] && ctrl_wr));

    // R6
    pend_from_period_chk: assert property (@(posedge clk) disable iff (!sys_arst_n)
        $rose(sys_q.pend) |-> $past(irq_hit));

    // R10
    cause_with_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_q.cause) |-> rst_req_o);

    // R11
    run_kept_in_sysrst_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !ctrl_wr) |=> $stable(por_q.run));

endmodule

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;

    localparam int ADDR_W    = 4;
    localparam int IRQ_EXP   = 4;
    localparam int RST_EXP   = 6;
    localparam int PULSE_LEN = 4;
    localparam int IRQ_CYC   = 1 << IRQ_EXP;
    localparam int RST_CYC   = 1 << RST_EXP;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              sys_rst_n = 1'b0;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic              pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              irq_o;
    logic              rst_req_o;

    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    wdog_top #(
        .ADDR_W    (ADDR_W),
        .IRQ_EXP   (IRQ_EXP),
        .RST_EXP   (RST_EXP),
        .PULSE_LEN (PULSE_LEN)
    ) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: compare read data against the scoreboard queue
    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected read", prdata, 32'hx);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, prdata, e);
            end
        end
    end

    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); #1 penable = 1'b1;
        @(negedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk); #1 penable = 1'b1;
        @(negedge clk); #1 psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) @(negedge clk);
        #1;
    endtask

    task automatic enable(logic [31:0] d);
        bus_wr(4'h0, 32'hA5);
        bus_wr(4'h0, 32'h5A);
        bus_wr(4'h0, d);
    endtask

    task automatic cycles_until(input bit want_irq, input bit level, output int n);
        n = 0;
        while (((want_irq ? irq_o : rst_req_o) !== level) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        #1;
    endtask

    task automatic por_cycle();
        por_n = 1'b0; sys_rst_n = 1'b0;
        idle(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        int n;
        @(negedge clk); #1;
        por_cycle();

        // R1 reset state
        check("R1 irq_o after por", irq_o, 0);
        check("R1 rst_req_o after por", rst_req_o, 0);
        bus_rd(4'h0, 32'h0, "R1 ctrl after por");
        bus_rd(4'h4, 32'h0, "R2 feed reg reads zero");

        // R2 reserved bits, R3 run stays locked
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, 32'h0000_0C00, "R2 reserved zero / R3 locked run");

        // R5 key words leave fields alone
        bus_wr(4'h0, 32'hA5);
        bus_rd(4'h0, 32'h0000_0C00, "R5 first key keeps fields");
        bus_wr(4'h0, 32'h5A);
        bus_rd(4'h0, 32'h0000_0C00, "R5 second key keeps fields");
        bus_wr(4'h0, 32'h0);
        bus_rd(4'h0, 32'h0, "R3 open lost on write without run");

        // R3 broken sequences
        bus_wr(4'h0, 32'hA5); bus_wr(4'h0, 32'h11); bus_wr(4'h0, 32'h5A); bus_wr(4'h0, 32'h100);
        bus_rd(4'h0, 32'h0, "R3 sequence broken by other write");
        enable(32'h0); bus_wr(4'h0, 32'h100);
        bus_rd(4'h0, 32'h0, "R3 third write must set run");

        // R3 good sequence, R6 period, R7 output
        enable(32'h500);
        cycles_until(1'b1, 1'b1, n);
        check("R6 interrupt period cycles", n, IRQ_CYC);
        check("R7 irq_o with mask", irq_o, 1);
        bus_wr(4'h0, 32'h100);
        check("R7 irq_o masked", irq_o, 0);
        bus_rd(4'h0, 32'h300, "R6 write 0 keeps pending / R3 run set");
        bus_wr(4'h0, 32'h300);
        bus_rd(4'h0, 32'h100, "R6 write 1 clears pending");

        // R4 stop without key, restart from zero
        bus_wr(4'h0, 32'h0);
        bus_rd(4'h0, 32'h0, "R4 run cleared without key");
        enable(32'h500);
        cycles_until(1'b1, 1'b1, n);
        check("R4 counter restarts from zero", n, IRQ_CYC);

        // R8 feed zeroes the counter
        bus_wr(4'h0, 32'h200);
        check("R7 irq_o after pending cleared", irq_o, 0);
        enable(32'h500);
        idle(5);
        bus_wr(4'h4, 32'hA5); bus_wr(4'h4, 32'h5A);
        cycles_until(1'b1, 1'b1, n);
        check("R8 feed restarts period", n, IRQ_CYC);
        bus_wr(4'h0, 32'h200);
        enable(32'h500);
        bus_wr(4'h4, 32'hA5); bus_wr(4'h4, 32'h12); bus_wr(4'h4, 32'h5A);
        cycles_until(1'b1, 1'b1, n);
        check("R8 broken feed ignored", n, IRQ_CYC - 6);

        // R9 reset request pulse
        bus_wr(4'h0, 32'h200);
        enable(32'h900);
        cycles_until(1'b0, 1'b1, n);
        check("R9 reset period cycles", n, RST_CYC);
        cycles_until(1'b0, 1'b0, n);
        check("R9 pulse length", n, PULSE_LEN);
        cycles_until(1'b0, 1'b1, n);
        check("R9 restart after pulse", n, RST_CYC);
        cycles_until(1'b0, 1'b0, n);

        // R10 cause flag
        bus_rd(4'h0, 32'h8000_0B00, "R10 cause set by request");
        bus_wr(4'h0, 32'h8000_0900);
        bus_rd(4'h0, 32'h8000_0B00, "R10 write 1 keeps cause");

        // R11 system reset keeps power-on fields
        sys_rst_n = 1'b0;
        idle(2);
        sys_rst_n = 1'b1;
        bus_rd(4'h0, 32'h8000_0900, "R11 sys reset keeps run/arm/cause");
        bus_wr(4'h0, 32'h0000_0900);
        bus_rd(4'h0, 32'h0000_0900, "R10 write 0 clears cause");

        // R11 power-on clears all
        por_cycle();
        bus_rd(4'h0, 32'h0, "R11 por clears all");
        check("R11 rst_req_o after por", rst_req_o, 0);

        idle(1);
        check("R2 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule